// File: doc/BRIEF.md
# Polled I/O and Interrupt Controller

This block sits between a small accumulator processor and two character devices: a keyboard that supplies bytes and a printer that consumes them. It holds an 8-bit receive register and an 8-bit transmit register, one ready flag for each side, the interrupt-enable flip-flop and the interrupt-cycle flip-flop. When the processor's I/O execute strobe is high, the block decodes a six-bit operation field taken from the instruction word. It then either moves a byte between the accumulator and a device register, asks for a conditional skip, or changes the interrupt-enable state.

The ready flags form a two-sided handshake. A device sets a flag when it deposits or takes a byte, and the matching instruction clears that flag. Between instructions the block may raise the interrupt-cycle flip-flop. It then drives a fixed three-step sequence on the first three sequence-counter steps:
- clear AR and copy PC into TR;
- write TR to memory word 0 and clear PC;
- step PC to 1, which leaves the handler to run from word 1.

Top module: `io_intr_ctrl`

## Requirements
- R1: Operations act only while `io_exec` is 1. The field `io_field` is instruction bits 11..6 and is decoded one-hot: bit 5 (IR11) input, bit 4 (IR10) output, bit 3 (IR9) skip-on-input, bit 2 (IR8) skip-on-output, bit 1 (IR7) enable-on, bit 0 (IR6) enable-off. With `io_exec` at 0, no field value has any effect.
- R2: The input operation raises `ac_wr_lo` in the same cycle, with `ac_wr_data` equal to the receive register. The input flag reads 0 after the next clock edge.
- R3: The output operation loads `acc_lo` into the transmit register (seen on `prn_data`) and clears the output flag, both at the next clock edge.
- R4: The skip-on-input and skip-on-output operations raise `pc_inc` in the same cycle exactly when their flag is 1.
- R5: Enable-on sets `ien` and enable-off clears it, at the next edge. If both are present in the same cycle, the clear wins. Every cycle with `io_exec` at 1 raises `sc_clr`.
- R6: `kbd_ready` equals (input flag is 0) and (no input operation this cycle). A transfer (`kbd_valid` and `kbd_ready`) loads `kbd_data` and sets the input flag.
- R7: `prn_valid` equals (output flag is 0) and (no output operation this cycle). A transfer (`prn_valid` and `prn_accept`) sets the output flag.
- R8: After reset: input flag 0, output flag 1, `ien` 0, `irq_cycle` 0, both data registers 0.
- R9: At an edge where `ien` is 1, either flag is 1 and `sc_val` is 3 or more, `irq_cycle` becomes 1.
- R10: While `irq_cycle` is 1, the block drives one step per sequence value. At `sc_val` 0 it raises `ar_clr` and `tr_ld_pc`. At 1 it raises `mem_wr_tr` (address 0) and `pc_clr`. At 2 it raises `pc_inc` and `sc_clr`, and at the next edge it clears `ien` and `irq_cycle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_exec | input | 1 | I/O instruction execute strobe |
| io_field | input | 6 | Instruction bits 11..6 |
| sc_val | input | 4 | Sequence counter value |
| acc_lo | input | 8 | Accumulator bits 7..0 |
| kbd_valid | input | 1 | Keyboard offers a byte |
| kbd_data | input | 8 | Keyboard byte |
| kbd_ready | output | 1 | Receive side can take a byte |
| prn_accept | input | 1 | Printer takes the byte |
| prn_valid | output | 1 | Transmit register holds an unsent byte |
| prn_data | output | 8 | Transmit register |
| ac_wr_lo | output | 1 | Write accumulator bits 7..0 |
| ac_wr_data | output | 8 | Receive register value for the accumulator |
| pc_inc | output | 1 | Increment PC |
| pc_clr | output | 1 | Clear PC |
| sc_clr | output | 1 | Clear sequence counter |
| ar_clr | output | 1 | Clear AR |
| tr_ld_pc | output | 1 | Load TR from PC |
| mem_wr_tr | output | 1 | Write TR to memory word 0 |
| in_flag | output | 1 | Input ready flag |
| out_flag | output | 1 | Output ready flag |
| ien | output | 1 | Interrupt enable |
| irq_cycle | output | 1 | Interrupt-cycle flip-flop |

## Verification
The bench first runs a polled sequence in which the enable is off: a keyboard byte arrives, skip-on-input sees the flag, and an input operation reads the byte. An output operation then follows a printer drain. This separates correct flag polarity from inverted or swapped flags. Next, enable-on is issued while a flag is pending, so the interrupt cycle must start after the execute step and walk its three steps. This tells a wrong set condition apart from a wrong step order. A long random phase then issues random and overlapping fields, including non-one-hot fields and fields on cycles without the strobe. Device traffic runs beside it, so that same-cycle conflicts between device loads and instruction clears are hit. Every output is compared on every cycle against a behavioural model.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int OP_CNT = 6;

  typedef struct packed {
    logic inp;
    logic outp;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_op_t;
endpackage

// File: rtl/ioc_decode.sv
module ioc_decode
  import ioc_pkg::*;
(
  input  logic              io_exec,
  input  logic [OP_CNT-1:0] io_field,
  output io_op_t            ops
);
  logic [OP_CNT-1:0] gated;

  generate
    for (genvar g = 0; g < OP_CNT; g++) begin : g_gate
      assign gated[g] = io_exec & io_field[g];
    end
  endgenerate

  assign ops = io_op_t'(gated);
endmodule

// File: rtl/ioc_flags.sv
module ioc_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inp_op,
  input  logic              out_op,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_data,
  output logic              kbd_ready,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic              prn_accept,
  output logic              prn_valid,
  output logic [DATA_W-1:0] prn_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              fgi,
  output logic              fgo
);
  logic              fgi_q, fgi_d, fgo_q, fgo_d;
  logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic              rx_take, tx_done;

  assign kbd_ready = ~fgi_q & ~inp_op;
  assign prn_valid = ~fgo_q & ~out_op;
  assign rx_take   = kbd_valid & kbd_ready;
  assign tx_done   = prn_accept & prn_valid;

  always_comb begin
    fgi_d = fgi_q;
    fgo_d = fgo_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (rx_take) begin
      fgi_d = 1'b1;
      rx_d  = kbd_data;
    end
    if (inp_op)  fgi_d = 1'b0;
    if (tx_done) fgo_d = 1'b1;
    if (out_op) begin
      fgo_d = 1'b0;
      tx_d  = acc_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fgi_q <= 1'b0;
      fgo_q <= 1'b1;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      fgi_q <= fgi_d;
      fgo_q <= fgo_d;
      if (rx_take) rx_q <= rx_d;
      if (out_op)  tx_q <= tx_d;
    end
  end

  assign prn_data = tx_q;
  assign rx_data  = rx_q;
  assign fgi      = fgi_q;
  assign fgo      = fgo_q;

  AST_INP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    inp_op |=> !fgi); // R2
  AST_OUT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_op |=> (!fgo && prn_data == $past(acc_lo))); // R3
  AST_KBD_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && kbd_ready) |=> (fgi && rx_data == $past(kbd_data))); // R6
  AST_PRN_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (prn_accept && prn_valid) |=> fgo); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fgi |=> $stable(rx_data)); // R6
endmodule

// File: rtl/ioc_irq.sv
module ioc_irq #(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ion_op,
  input  logic            iof_op,
  input  logic            fgi,
  input  logic            fgo,
  input  logic [SC_W-1:0] sc_val,
  output logic            ien,
  output logic            irq_cycle,
  output logic            rt0,
  output logic            rt1,
  output logic            rt2
);
  localparam logic [SC_W-1:0] STEP0 = SC_W'(0);
  localparam logic [SC_W-1:0] STEP1 = SC_W'(1);
  localparam logic [SC_W-1:0] STEP2 = SC_W'(2);

  logic ien_q, ien_d, r_q, r_d, past_fetch;

  assign rt0        = r_q & (sc_val == STEP0);
  assign rt1        = r_q & (sc_val == STEP1);
  assign rt2        = r_q & (sc_val == STEP2);
  assign past_fetch = sc_val > STEP2;

  always_comb begin
    ien_d = ien_q;
    r_d   = r_q;
    if (ion_op) ien_d = 1'b1;
    if (iof_op || rt2) ien_d = 1'b0;
    if (ien_q && (fgi || fgo) && past_fetch) r_d = 1'b1;
    if (rt2) r_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      r_q   <= 1'b0;
    end else begin
      ien_q <= ien_d;
      r_q   <= r_d;
    end
  end

  assign ien       = ien_q;
  assign irq_cycle = r_q;

  AST_ION_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ion_op && !iof_op && !rt2) |=> ien); // R5
  AST_IOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    iof_op |=> !ien); // R5
  AST_R_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && (fgi || fgo) && past_fetch) |=> irq_cycle); // R9
  AST_RT2_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rt2 |=> (!irq_cycle && !ien)); // R10
  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rt0, rt1, rt2})); // R10
endmodule

// File: rtl/io_intr_ctrl.sv
module io_intr_ctrl
  import ioc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_exec,
  input  logic [5:0]        io_field,
  input  logic [SC_W-1:0]   sc_val,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_data,
  output logic              kbd_ready,
  input  logic              prn_accept,
  output logic              prn_valid,
  output logic [DATA_W-1:0] prn_data,
  output logic              ac_wr_lo,
  output logic [DATA_W-1:0] ac_wr_data,
  output logic              pc_inc,
  output logic              pc_clr,
  output logic              sc_clr,
  output logic              ar_clr,
  output logic              tr_ld_pc,
  output logic              mem_wr_tr,
  output logic              in_flag,
  output logic              out_flag,
  output logic              ien,
  output logic              irq_cycle
);
  io_op_t ops;
  logic   fgi, fgo, rt0, rt1, rt2;

  ioc_decode u_dec (
    .io_exec (io_exec),
    .io_field(io_field),
    .ops     (ops)
  );

  ioc_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .inp_op    (ops.inp),
    .out_op    (ops.outp),
    .kbd_valid (kbd_valid),
    .kbd_data  (kbd_data),
    .kbd_ready (kbd_ready),
    .acc_lo    (acc_lo),
    .prn_accept(prn_accept),
    .prn_valid (prn_valid),
    .prn_data  (prn_data),
    .rx_data   (ac_wr_data),
    .fgi       (fgi),
    .fgo       (fgo)
  );

  ioc_irq #(.SC_W(SC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ion_op   (ops.ion),
    .iof_op   (ops.iof),
    .fgi      (fgi),
    .fgo      (fgo),
    .sc_val   (sc_val),
    .ien      (ien),
    .irq_cycle(irq_cycle),
    .rt0      (rt0),
    .rt1      (rt1),
    .rt2      (rt2)
  );

  assign ac_wr_lo  = ops.inp;
  assign pc_inc    = (ops.ski & fgi) | (ops.sko & fgo) | rt2;
  assign pc_clr    = rt1;
  assign sc_clr    = io_exec | rt2;
  assign ar_clr    = rt0;
  assign tr_ld_pc  = rt0;
  assign mem_wr_tr = rt1;
  assign in_flag   = fgi;
  assign out_flag  = fgo;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_exec && !irq_cycle) |-> !(ac_wr_lo || pc_inc || sc_clr)); // R1
  AST_SKIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !irq_cycle) |-> (in_flag || out_flag)); // R4
  AST_MEM_PC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_tr |-> (pc_clr && !ar_clr)); // R10
endmodule

// File: tb/io_intr_ctrl_tb_top.sv
module io_intr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_exec;
  logic [5:0] io_field;
  logic [3:0] sc_val;
  logic [7:0] acc_lo, kbd_data, prn_data, ac_wr_data;
  logic       kbd_valid, kbd_ready, prn_accept, prn_valid, ac_wr_lo;
  logic       pc_inc, pc_clr, sc_clr, ar_clr, tr_ld_pc, mem_wr_tr;
  logic       in_flag, out_flag, ien, irq_cycle;

  always #2 clk = ~clk;

  io_intr_ctrl dut_i (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;
  int op_q[$];
  int kv_pct = 30;
  int pa_pct = 30;

  bit       m_fgi, m_fgo, m_ien, m_r;
  bit [7:0] m_rx, m_tx;
  int       sc;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cycle();
    bit       ex, inp, outp, ski, sko, ion, iof, rt0, rt1, rt2;
    bit       krdy, pval, e_pcinc, e_scclr;
    bit [5:0] fld;
    @(negedge clk);
    ex = 0;
    fld = 6'($urandom);
    if (sc == 3 && !m_r && op_q.size() > 0) begin
      fld = 6'(op_q.pop_front());
      ex = 1;
    end
    io_exec    = ex;
    io_field   = fld;
    sc_val     = 4'(sc);
    acc_lo     = 8'($urandom);
    kbd_valid  = ($urandom % 100) < kv_pct;
    kbd_data   = 8'($urandom);
    prn_accept = ($urandom % 100) < pa_pct;
    #1;
    inp  = ex & fld[5]; outp = ex & fld[4]; ski = ex & fld[3];
    sko  = ex & fld[2]; ion  = ex & fld[1]; iof = ex & fld[0];
    rt0  = m_r && sc == 0; rt1 = m_r && sc == 1; rt2 = m_r && sc == 2;
    krdy = !m_fgi && !inp;
    pval = !m_fgo && !outp;
    e_pcinc = (ski && m_fgi) || (sko && m_fgo) || rt2;
    e_scclr = ex || rt2;
    chk("R1", "ac_wr_lo", ac_wr_lo, inp);
    chk("R2", "ac_wr_data", ac_wr_data, m_rx);
    chk("R3", "prn_data", prn_data, m_tx);
    chk("R4", "pc_inc", pc_inc, e_pcinc);
    chk("R5", "sc_clr", sc_clr, e_scclr);
    chk("R5", "ien", ien, m_ien);
    chk("R6", "kbd_ready", kbd_ready, krdy);
    chk("R6", "in_flag", in_flag, m_fgi);
    chk("R7", "prn_valid", prn_valid, pval);
    chk("R7", "out_flag", out_flag, m_fgo);
    chk("R9", "irq_cycle", irq_cycle, m_r);
    chk("R10", "ar_clr", ar_clr, rt0);
    chk("R10", "tr_ld_pc", tr_ld_pc, rt0);
    chk("R10", "mem_wr_tr", mem_wr_tr, rt1);
    chk("R10", "pc_clr", pc_clr, rt1);
    // model update for the coming edge
    if (!m_r || !rt2) begin
      if (m_ien && (m_fgi || m_fgo) && sc > 2) m_r = 1;
    end
    if (rt2) m_r = 0;
    if (ion) m_ien = 1;
    if (iof || rt2) m_ien = 0;
    if (kbd_valid && krdy) begin m_fgi = 1; m_rx = kbd_data; end
    if (inp) m_fgi = 0;
    if (prn_accept && pval) m_fgo = 1;
    if (outp) begin m_fgo = 0; m_tx = acc_lo; end
    if (e_scclr) sc = 0;
    else sc = (sc >= 5) ? 0 : sc + 1;
  endtask

  task automatic run_until_empty(int limit);
    for (int i = 0; i < limit && op_q.size() > 0; i++) cycle();
    for (int i = 0; i < 8; i++) cycle();
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; io_exec = 0; io_field = 0; sc_val = 0; acc_lo = 0;
    kbd_valid = 0; kbd_data = 0; prn_accept = 0;
    m_fgi = 0; m_fgo = 1; m_ien = 0; m_r = 0; m_rx = 0; m_tx = 0; sc = 0;
    #9;
    chk("R8", "reset in_flag", in_flag, 0);
    chk("R8", "reset out_flag", out_flag, 1);
    chk("R8", "reset ien", ien, 0);
    chk("R8", "reset irq_cycle", irq_cycle, 0);
    chk("R8", "reset prn_data", prn_data, 0);
    rst_n = 1;
    // polled receive and transmit, interrupts off
    kv_pct = 100; pa_pct = 100;
    op_q.push_back(6'b001000); // skip on input
    op_q.push_back(6'b100000); // input
    op_q.push_back(6'b000100); // skip on output
    op_q.push_back(6'b010000); // output
    op_q.push_back(6'b000100);
    run_until_empty(200);
    // interrupt entry with flags pending
    op_q.push_back(6'b000010); // enable on
    run_until_empty(200);
    chk("R10", "ien after entry", ien, m_ien);
    op_q.push_back(6'b000010);
    op_q.push_back(6'b000011); // on and off together
    run_until_empty(200);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      kv_pct = $urandom % 100;
      pa_pct = $urandom % 100;
      if (op_q.size() == 0) begin
        if ($urandom % 4 == 0) op_q.push_back(int'($urandom % 64));
        else op_q.push_back(1 << ($urandom % 6));
      end
      cycle();
    end
    finish_run();
  end
endmodule